// File: doc/BRIEF.md
# Interleaved Tile Scanline Fetcher

This block reads one pixel row from a run of 8×8 tiles. The tiles sit in a 16 KB image in external memory. The image has no header and is stored row-plane by row-plane: pixel row N of every one of the 256 tiles shares one contiguous 2048-byte plane, and each tile owns 8 bytes of that plane. A row of many adjacent tiles is therefore one linear stretch of addresses.

A request names a row (0–7), a first tile and a tile count. The fetcher works out the byte address of the run. It issues read bursts to a generic word-wide memory port, cutting the run into bursts no longer than a configured word limit. It then breaks the returned words into a stream of 8-bit pixels, lowest address first, on a valid/ready output.

A burst is issued only when the word buffer has room for all of its data. That way a stalled pixel consumer can never make the buffer overflow. A one-cycle done pulse closes each request, and a clipping flag accompanies that pulse when the run had to be cut short at tile 255.

Top module: `tile_row_fetch`

## Requirements
- R1: The first burst of a request starts at byte address row × 2048 + tile × 8 (for example tile 2 row 2 → 0x1010, tile 5 row 3 → 0x1828, tile 42 row 7 → 0x3950). `mem_cmd_addr` is a byte address.
- R2: `mem_cmd_len` counts words and is never 0 or more than 2^COL_BITS. Each further burst of the same request starts at the previous address plus len × (DATA_W/8). The lengths of all bursts add up to tiles × 8 / (DATA_W/8). While a command waits for `mem_cmd_ready`, its valid, address and length stay unchanged.
- R3: Pixels leave in ascending address order, one byte per pixel. Byte lane k (bits 8k+7:8k) of a returned word holds the byte at the lower address before lane k+1, so lane 0 is the lowest address.
- R4: The run is cut to min(count, 256 − tile) tiles. `clip_err` is high during the done pulse of a request that was cut, and low at every other time.
- R5: A burst is issued only if the words already buffered, plus the words still outstanding, plus the new length, do not exceed FIFO_DEPTH.
- R6: `done` is high for exactly one cycle, in the cycle after the last pixel of a request is accepted. `req_ready` is low from acceptance until that pulse.
- R7: A request with count 0 issues no burst and no pixel, and raises `done` in the cycle after it is accepted, with `clip_err` low.
- R8: After reset `req_ready` is 1, and `mem_cmd_valid`, `pix_valid` and `done` are 0.
- R9: While `pix_valid` is high and `pix_ready` is low, `pix_valid` stays high and `pix_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Fetcher idle, request accepted |
| req_row | input | 3 | Pixel row inside the tiles |
| req_tile | input | 8 | First tile index |
| req_count | input | 9 | Number of tiles (0–511) |
| mem_cmd_valid | output | 1 | Burst read command present |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_addr | output | 14 | Byte address of the burst |
| mem_cmd_len | output | COL_BITS+1 | Burst length in words |
| mem_rd_valid | input | 1 | Returned word present, in command order |
| mem_rd_data | input | DATA_W | Returned word, little-endian lanes |
| pix_valid | output | 1 | Pixel present |
| pix_ready | input | 1 | Consumer accepts the pixel |
| pix_data | output | 8 | Pixel byte |
| done | output | 1 | One-cycle end-of-request pulse |
| clip_err | output | 1 | Request was clipped at tile 255 (with done) |

## Verification
The assertions watch every cycle for the limit on burst length and the reservation bound on the word buffer. They also check that commands and pixels hold steady under back-pressure, that the fetcher stays silent when idle, that a clipping flag always comes with a done pulse, and that the done pulse follows the last pixel. Only the bench scenarios can show that addresses match the row-plane formula, that split bursts chain at consecutive addresses, and that the pixel bytes come out in lane order. The same holds for clipping at tile 255, the zero-count request, and the buffer filling to exactly its depth while the consumer stalls.

// File: rtl/tfetch_pkg.sv
package tfetch_pkg;
  localparam int ROWS        = 8;
  localparam int TILES       = 256;
  localparam int TILE_BYTES  = 8;
  localparam int PLANE_BYTES = TILES * TILE_BYTES;
  localparam int IMG_BYTES   = ROWS * PLANE_BYTES;
  localparam int ADDR_W      = $clog2(IMG_BYTES);
  localparam int ROW_W       = $clog2(ROWS);
  localparam int TILE_W      = $clog2(TILES);
  localparam int CNT_W       = TILE_W + 1;
  localparam int PIX_CNT_W   = $clog2(PLANE_BYTES + 1);

  // byte address of one tile's slice inside a row plane
  function automatic logic [ADDR_W-1:0] plane_addr(input logic [ROW_W-1:0] row,
                                                   input logic [TILE_W-1:0] tile);
    return ADDR_W'(row) * ADDR_W'(PLANE_BYTES) + ADDR_W'(tile) * ADDR_W'(TILE_BYTES);
  endfunction

  // tiles actually fetched: the run stops at the last tile of the plane
  function automatic logic [CNT_W-1:0] clip_tiles(input logic [TILE_W-1:0] first,
                                                  input logic [CNT_W-1:0]  cnt);
    logic [CNT_W-1:0] room;
    room = CNT_W'(TILES) - CNT_W'(first);
    return (cnt > room) ? room : cnt;
  endfunction

  function automatic logic [PIX_CNT_W-1:0] pix_for(input logic [CNT_W-1:0] tiles);
    return PIX_CNT_W'(tiles) * PIX_CNT_W'(TILE_BYTES);
  endfunction
endpackage

// File: rtl/tfetch_cmd_gen.sv
module tfetch_cmd_gen
  import tfetch_pkg::*;
#(
  parameter int BPW         = 4,
  parameter int BURST_WORDS = 256,
  parameter int DEPTH       = 256,
  parameter int LEN_W       = 9,
  parameter int WL_W        = 10,
  parameter int RES_W       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [WL_W-1:0]   start_words,
  input  logic [RES_W-1:0]  resv,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_fire
);
  logic [ADDR_W-1:0] addr_q;
  logic [WL_W-1:0]   left_q;
  logic              room_ok;

  always_comb begin
    if (32'(left_q) > BURST_WORDS) cmd_len = LEN_W'(BURST_WORDS);
    else                           cmd_len = LEN_W'(left_q);
  end

  // whole burst must fit beside what is buffered or still in flight
  assign room_ok   = (32'(resv) + 32'(cmd_len)) <= DEPTH;
  assign cmd_valid = (left_q != '0) && room_ok;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign cmd_addr  = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (start) begin
      addr_q <= start_addr;
      left_q <= start_words;
    end else if (cmd_fire) begin
      addr_q <= addr_q + ADDR_W'(32'(cmd_len) * BPW);
      left_q <= left_q - WL_W'(cmd_len);
    end
  end
endmodule

// File: rtl/tfetch_word_fifo.sv
module tfetch_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wr_q, rd_q;

  assign empty = (wr_q == rd_q);
  assign dout  = mem_q[rd_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop)  rd_q <= rd_q + 1'b1;
    end
  end
endmodule

// File: rtl/tfetch_unpack.sv
module tfetch_unpack
  import tfetch_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [PIX_CNT_W-1:0] start_pix,
  input  logic [DATA_W-1:0]    word,
  input  logic                 word_ok,
  output logic                 pix_valid,
  input  logic                 pix_ready,
  output logic [7:0]           pix_data,
  output logic                 pop,
  output logic                 last_fire
);
  localparam int BPW    = DATA_W / 8;
  localparam int LANE_W = $clog2(BPW);

  logic [7:0]           lanes [BPW];
  logic [LANE_W-1:0]    lane_q;
  logic [PIX_CNT_W-1:0] left_q;
  logic                 fire, last_lane;

  for (genvar g = 0; g < BPW; g++) begin : g_lane
    assign lanes[g] = word[g*8 +: 8];
  end

  assign pix_valid = word_ok && (left_q != '0);
  assign pix_data  = lanes[lane_q];
  assign fire      = pix_valid && pix_ready;
  assign last_lane = (lane_q == LANE_W'(BPW - 1));
  assign pop       = fire && last_lane;
  assign last_fire = fire && (left_q == PIX_CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      left_q <= '0;
    end else if (start) begin
      lane_q <= '0;
      left_q <= start_pix;
    end else if (fire) begin
      lane_q <= last_lane ? '0 : lane_q + 1'b1;
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/tile_row_fetch.sv
module tile_row_fetch
  import tfetch_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int COL_BITS   = 8,
  parameter int FIFO_DEPTH = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ROW_W-1:0]    req_row,
  input  logic [TILE_W-1:0]   req_tile,
  input  logic [CNT_W-1:0]    req_count,
  output logic                mem_cmd_valid,
  input  logic                mem_cmd_ready,
  output logic [ADDR_W-1:0]   mem_cmd_addr,
  output logic [COL_BITS:0]   mem_cmd_len,
  input  logic                mem_rd_valid,
  input  logic [DATA_W-1:0]   mem_rd_data,
  output logic                pix_valid,
  input  logic                pix_ready,
  output logic [7:0]          pix_data,
  output logic                done,
  output logic                clip_err
);
  localparam int BPW         = DATA_W / 8;
  localparam int BURST_WORDS = 1 << COL_BITS;
  localparam int LEN_W       = COL_BITS + 1;
  localparam int WL_W        = $clog2(PLANE_BYTES / BPW + 1);
  localparam int RES_W       = $clog2(FIFO_DEPTH + 1);

  logic                 busy_q, clip_q, done_q;
  logic [RES_W-1:0]     resv_q;
  logic                 req_fire, start, cmd_fire, word_pop, last_pix, fifo_empty;
  logic [CNT_W-1:0]     eff_tiles;
  logic [PIX_CNT_W-1:0] start_pix;
  logic [WL_W-1:0]      start_words;
  logic [DATA_W-1:0]    head_word;

  assign req_ready   = !busy_q;
  assign req_fire    = req_valid && req_ready;
  assign eff_tiles   = clip_tiles(req_tile, req_count);
  assign start       = req_fire && (eff_tiles != '0);
  assign start_pix   = pix_for(eff_tiles);
  assign start_words = WL_W'(start_pix / PIX_CNT_W'(BPW));

  tfetch_cmd_gen #(
    .BPW(BPW), .BURST_WORDS(BURST_WORDS), .DEPTH(FIFO_DEPTH),
    .LEN_W(LEN_W), .WL_W(WL_W), .RES_W(RES_W)
  ) u_cmd (
    .clk(clk), .rst_n(rst_n), .start(start),
    .start_addr(plane_addr(req_row, req_tile)), .start_words(start_words),
    .resv(resv_q), .cmd_valid(mem_cmd_valid), .cmd_ready(mem_cmd_ready),
    .cmd_addr(mem_cmd_addr), .cmd_len(mem_cmd_len), .cmd_fire(cmd_fire)
  );

  tfetch_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(mem_rd_valid), .din(mem_rd_data),
    .pop(word_pop), .dout(head_word), .empty(fifo_empty)
  );

  tfetch_unpack #(.DATA_W(DATA_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .start(start), .start_pix(start_pix),
    .word(head_word), .word_ok(!fifo_empty), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data), .pop(word_pop), .last_fire(last_pix)
  );

  // words buffered plus words requested but not yet returned
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resv_q <= '0;
    else        resv_q <= resv_q + (cmd_fire ? RES_W'(mem_cmd_len) : '0)
                                 - (word_pop ? RES_W'(1) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      clip_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_pix || (req_fire && (eff_tiles == '0));
      if (req_fire) clip_q <= (eff_tiles != req_count);
      if (start)         busy_q <= 1'b1;
      else if (last_pix) busy_q <= 1'b0;
    end
  end

  assign done     = done_q;
  assign clip_err = done_q && clip_q;
endmodule

// File: rtl/tfetch_checker.sv
module tfetch_checker #(
  parameter int DEPTH       = 256,
  parameter int BURST_WORDS = 256,
  parameter int LEN_W       = 9,
  parameter int RES_W       = 9,
  parameter int ADDR_W      = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_cmd_valid,
  input logic              mem_cmd_ready,
  input logic [ADDR_W-1:0] mem_cmd_addr,
  input logic [LEN_W-1:0]  mem_cmd_len,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic [7:0]        pix_data,
  input logic              done,
  input logic              clip_err,
  input logic              last_pix,
  input logic [RES_W-1:0]  resv_q
);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(resv_q) <= DEPTH);

  p_len_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> (mem_cmd_len != '0) && (32'(mem_cmd_len) <= BURST_WORDS));

  p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !mem_cmd_ready |=>
      mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_len));

  p_pix_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_data));

  p_err_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clip_err |-> done);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_cmd_valid && !pix_valid);

  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_pix |=> done);
endmodule

bind tile_row_fetch tfetch_checker #(
  .DEPTH(FIFO_DEPTH), .BURST_WORDS(1 << COL_BITS), .LEN_W(COL_BITS + 1),
  .RES_W($clog2(FIFO_DEPTH + 1)), .ADDR_W(tfetch_pkg::ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
  .mem_cmd_addr(mem_cmd_addr), .mem_cmd_len(mem_cmd_len),
  .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
  .done(done), .clip_err(clip_err), .last_pix(last_pix), .resv_q(resv_q)
);

// File: tb/tile_row_fetch_test.sv
`timescale 1ns/1ps
module tile_row_fetch_test;
  localparam int DW = 16, CB = 4, FD = 16;
  localparam int BPW = DW / 8, BURST = 1 << CB;
  // row, first tile, count, handshake mode (0 free-running, 1 random gaps)
  localparam int NV = 8;
  localparam int VT [NV][4] = '{
    '{2, 2, 1, 0}, '{3, 5, 2, 0}, '{7, 42, 3, 1}, '{0, 0, 9, 1},
    '{5, 250, 10, 0}, '{1, 255, 1, 1}, '{4, 100, 20, 1}, '{6, 200, 100, 1}};

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic          req_valid = 0, req_ready;
  logic [2:0]    req_row = 0;
  logic [7:0]    req_tile = 0;
  logic [8:0]    req_count = 0;
  logic          mem_cmd_valid, mem_cmd_ready = 0;
  logic [13:0]   mem_cmd_addr;
  logic [CB:0]   mem_cmd_len;
  logic          mem_rd_valid = 0;
  logic [DW-1:0] mem_rd_data = '0;
  logic          pix_valid, pix_ready = 0, done, clip_err;
  logic [7:0]    pix_data;

  tile_row_fetch #(.DATA_W(DW), .COL_BITS(CB), .FIFO_DEPTH(FD)) uut (.*);

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] img_byte(input int a);
    return 8'((a * 37 + (a >> 7) + 11) & 255);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // memory model and output monitor, all at the falling edge
  logic [15:0] lfsr = 16'hACE1;
  int mode = 0;
  bit stall = 0;
  int qa [256], ql [256];
  int qw = 0, qr = 0, wofs = 0;
  int cmd_n, first_addr, next_addr, addr_bad, len_bad, occ_bad, issued_w;
  int pix_n, pix_bad, done_n, err_n, last_pix_cyc, done_cyc, base_exp;

  always @(negedge clk) begin
    logic cr, pr, rv;
    int nq;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    nq = qw;
    cr = (mode == 1) ? lfsr[1] : 1'b1;
    pr = (mode == 1) ? (lfsr[2] | lfsr[5]) : !stall;
    rv = (qr != nq) && ((mode == 1) ? (lfsr[7] | lfsr[9]) : 1'b1);
    mem_cmd_ready = cr;
    pix_ready     = pr;
    mem_rd_valid  = rv;
    if (rv) begin
      for (int k = 0; k < BPW; k++)
        mem_rd_data[k*8 +: 8] = img_byte(qa[qr] + wofs * BPW + k);
      wofs++;
      if (wofs == ql[qr]) begin wofs = 0; qr = (qr + 1) % 256; end
    end
    if (mem_cmd_valid && cr) begin
      if (cmd_n == 0) first_addr = int'(mem_cmd_addr);
      else if (int'(mem_cmd_addr) != next_addr) addr_bad++;
      if (mem_cmd_len == 0 || int'(mem_cmd_len) > BURST) len_bad++;
      if (issued_w - pix_n / BPW + int'(mem_cmd_len) > FD) occ_bad++;
      next_addr = int'(mem_cmd_addr) + int'(mem_cmd_len) * BPW;
      issued_w += int'(mem_cmd_len);
      cmd_n++;
      qa[qw] = int'(mem_cmd_addr); ql[qw] = int'(mem_cmd_len); qw = (qw + 1) % 256;
    end
    if (pix_valid && pr) begin
      if (pix_data != img_byte(base_exp + pix_n)) pix_bad++;
      pix_n++;
      last_pix_cyc = cyc;
    end
    if (done) begin
      done_n++;
      done_cyc = cyc;
    end
    if (clip_err) err_n++;
  end

  task automatic run_req(input int row, input int tile, input int cnt,
                         input int md, input int stall_cyc);
    int eff, to;
    logic [7:0] held;
    eff = (cnt > 256 - tile) ? 256 - tile : cnt;
    @(negedge clk);
    mode = md; stall = (stall_cyc > 0);
    base_exp = row * 2048 + tile * 8;
    cmd_n = 0; addr_bad = 0; len_bad = 0; occ_bad = 0; issued_w = 0;
    pix_n = 0; pix_bad = 0; done_n = 0; err_n = 0; first_addr = -1;
    req_row = 3'(row); req_tile = 8'(tile); req_count = 9'(cnt); req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (stall_cyc > 0) begin
      repeat (10) @(negedge clk);
      held = pix_data;
      chk("R3 first pixel of stalled run", int'(pix_data), int'(img_byte(base_exp)));
      repeat (stall_cyc) @(negedge clk);
      chk("R5 words issued while consumer stalls", issued_w, FD);
      chk("R9 pixel held under stall", int'(pix_data), int'(held));
      chk("R9 pixel valid held under stall", int'(pix_valid), 1);
      stall = 0;
    end
    to = 0;
    while (done_n == 0 && to < 5000) begin @(negedge clk); to++; end
    if (to >= 5000) chk("R6 watchdog waiting for done", 0, 1);
    repeat (3) @(negedge clk);
    if (eff > 0) chk("R1 first burst address", first_addr, base_exp);
    chk("R2 bursts chained at consecutive addresses", addr_bad, 0);
    chk("R2 burst length within limit", len_bad, 0);
    chk("R2 total words requested", issued_w, eff * 8 / BPW);
    chk("R3 pixel bytes in address order", pix_bad, 0);
    chk("R4 pixel count after clipping", pix_n, eff * 8);
    chk("R4 clip flag", err_n, (cnt > eff) ? 1 : 0);
    chk("R5 buffer reservation", occ_bad, 0);
    chk("R6 single done pulse", done_n, 1);
    if (eff > 0) chk("R6 done one cycle after last pixel", done_cyc - last_pix_cyc, 1);
    else chk("R7 zero count issues no burst", cmd_n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R8 req_ready in reset", int'(req_ready), 1);
    chk("R8 mem_cmd_valid in reset", int'(mem_cmd_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R8 pix_valid after reset", int'(pix_valid), 0);
    chk("R8 done after reset", int'(done), 0);
    for (int v = 0; v < NV; v++)
      run_req(VT[v][0], VT[v][1], VT[v][2], VT[v][3], 0);
    // R7: empty request
    run_req(3, 10, 0, 0, 0);
    // R5 / R9: consumer stalled, 12 tiles need 48 words but only 16 fit
    run_req(2, 60, 12, 2, 200);
    // R4: oversize count starting at tile 0
    run_req(7, 0, 300, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule